// File: doc/BRIEF.md
# Receive Link Load Meter

This block watches the receive data-valid line of a media-independent interface and reports how busy the link was over a programmable measurement window. The figure does not depend on frame size: every frame end found in the window is credited with one minimum inter-frame gap (24 clock cycles at a 25 MHz nibble clock), and that credit is added to the number of cycles during which data-valid was high. A link carrying back-to-back frames therefore reads 100 % whether its frames are short or long.

Windows follow each other with no gap. When a window closes, its counters clear and the next window starts on the following cycle. In parallel, a seven-step serial divider turns the closed window's sum into a whole percentage. That percentage is published with a one-cycle strobe. The threshold test needs no divider: it compares 100 × sum against threshold × window length. When the load is above the threshold, a sticky request flag is set. The flag stays high until the clear input is pulsed.

The controller is a three-state machine. ST_MEASURE is the idle-divider state in which only the counters run. The transition "window closes" leads to ST_DIVIDE. ST_DIVIDE stays in itself for "next quotient bit" while bits remain. It moves to ST_PUBLISH on "last bit resolved". ST_PUBLISH returns to ST_MEASURE on "strobe issued" after one cycle.

Top module: `link_load_meter`

## Requirements
- R1: The window length in clock cycles is `win_len`, and any value below 16 is treated as 16. Windows run back to back from the first cycle after reset release. For each window, `win_done` is high for exactly one cycle, seven clock edges after the edge that samples the window's last cycle.
- R2: Each sampled cycle with `rx_dv` high adds one to the window's active count. Cycles with `rx_dv` low add nothing to it.
- R3: A frame end is a sampled cycle with `rx_dv` low whose previous sampled cycle had `rx_dv` high. It is counted in the window that contains the low sample, including when the high sample lies in the previous window.
- R4: The window sum is S = 24 × frame ends + active cycles. `load_pct` = floor(100 × S / window length), saturated at 100.
- R5: `load_pct` changes only in a cycle where `win_done` is high and holds its value otherwise.
- R6: A window is over threshold when 100 × S > `thresh_pct` × window length (strict). An over-threshold window sets `reconf_req` in its `win_done` cycle.
- R7: `reconf_req` stays set until `req_clr` is sampled high; it is low in the following cycle unless a new set occurs at that same edge.
- R8: While `rst_n` is low, `load_pct` is 0, `win_done` is 0 and `reconf_req` is 0, and all counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data-valid |
| win_len | input | WIN_W | Window length in cycles (minimum 16) |
| thresh_pct | input | 7 | Load threshold in percent |
| req_clr | input | 1 | Clears the request flag |
| load_pct | output | 7 | Load of the last closed window, 0 to 100 |
| win_done | output | 1 | One-cycle strobe when a new load value is published |
| reconf_req | output | 1 | Sticky over-threshold request |

## Verification
On every cycle, the assertions hold the strobe to a single cycle and keep the published percentage at or below 100 and unchanged between strobes. They also keep the request flag sticky, allow it to rise only with the strobe, and require it to drop after a clear. Only the bench scenarios can show that the arithmetic is right. They cover frame-size independence at line rate, floor rounding, the strict threshold boundary, the clamp on short windows, and a frame end that falls just across a window boundary.

// File: rtl/llm_pkg.sv
package llm_pkg;
    typedef enum logic [1:0] {
        ST_MEASURE,
        ST_DIVIDE,
        ST_PUBLISH
    } meter_state_t;

    localparam int PCT_W    = 7;
    localparam int PCT_FULL = 100;
    localparam int STEP_W   = 3;
endpackage

// File: rtl/llm_window_timer.sv
module llm_window_timer #(
    parameter int WIN_W   = 16,
    parameter int MIN_WIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_end,
    output logic [WIN_W-1:0] eff_len
);
    logic [WIN_W-1:0] cyc_cnt;

    always_comb begin
        eff_len = (win_len < WIN_W'(MIN_WIN)) ? WIN_W'(MIN_WIN) : win_len;
        win_end = (cyc_cnt >= (eff_len - WIN_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_cnt <= '0;
        else if (win_end)
            cyc_cnt <= '0;
        else
            cyc_cnt <= cyc_cnt + WIN_W'(1);
    end

    // R1: windows are at least 16 cycles, so two closes never touch
    p_win_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end);
endmodule

// File: rtl/llm_activity_acc.sv
module llm_activity_acc #(
    parameter int WIN_W   = 16,
    parameter int SUM_W   = 21,
    parameter int IFG_CYC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic             win_end,
    output logic [SUM_W-1:0] sum_now
);
    logic [WIN_W-1:0] act_cnt;
    logic [WIN_W-1:0] frm_cnt;
    logic [WIN_W-1:0] act_next;
    logic [WIN_W-1:0] frm_next;
    logic             dv_q;
    logic             frame_end;

    always_comb begin
        frame_end = dv_q & ~rx_dv;
        act_next  = act_cnt + WIN_W'(rx_dv);
        frm_next  = frm_cnt + WIN_W'(frame_end);
        sum_now   = SUM_W'(frm_next) * SUM_W'(IFG_CYC) + SUM_W'(act_next);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt <= '0;
            frm_cnt <= '0;
            dv_q    <= 1'b0;
        end else begin
            dv_q <= rx_dv;
            if (win_end) begin
                act_cnt <= '0;
                frm_cnt <= '0;
            end else begin
                act_cnt <= act_next;
                frm_cnt <= frm_next;
            end
        end
    end

    // R2: an idle cycle leaves the active count alone
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv && !win_end) |=> (act_cnt == $past(act_cnt)));

    // R3: at most one frame end per cycle
    p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ((frm_cnt == $past(frm_cnt)) ||
                      (frm_cnt == $past(frm_cnt) + WIN_W'(1))));
endmodule

// File: rtl/llm_ratio_fsm.sv
module llm_ratio_fsm
    import llm_pkg::*;
#(
    parameter int WIN_W  = 16,
    parameter int SUM_W  = 21,
    parameter int PROD_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  logic [SUM_W-1:0] sum_now,
    input  logic [WIN_W-1:0] eff_len,
    input  logic [PCT_W-1:0] thresh_pct,
    input  logic             req_clr,
    output logic [PCT_W-1:0] load_pct,
    output logic             win_done,
    output logic             reconf_req
);
    meter_state_t      state;
    meter_state_t      state_nxt;
    logic [STEP_W-1:0] step;
    logic [PROD_W-1:0] rem;
    logic [WIN_W-1:0]  den;
    logic [PCT_W-1:0]  quot;
    logic              over_q;

    logic [PROD_W-1:0] prod_now;
    logic [PROD_W-1:0] lim_now;
    logic [PROD_W-1:0] trial;
    logic              fits;
    logic [PCT_W-1:0]  quot_nxt;
    logic [PCT_W-1:0]  pct_sat;
    logic              last_bit;

    always_comb begin
        prod_now = PROD_W'(sum_now) * PROD_W'(PCT_FULL);
        lim_now  = PROD_W'(thresh_pct) * PROD_W'(eff_len);
        trial    = PROD_W'(den) << step;
        fits     = (rem >= trial);
        quot_nxt = quot | (PCT_W'(fits) << step);
        pct_sat  = (quot_nxt > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : quot_nxt;
        last_bit = (state == ST_DIVIDE) && (step == '0);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_MEASURE: if (win_end)        state_nxt = ST_DIVIDE;
            ST_DIVIDE:  if (step == '0)     state_nxt = ST_PUBLISH;
            ST_PUBLISH:                     state_nxt = ST_MEASURE;
            default:                        state_nxt = ST_MEASURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_MEASURE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= '0;
            rem      <= '0;
            den      <= '0;
            quot     <= '0;
            over_q   <= 1'b0;
            load_pct <= '0;
        end else begin
            if (state == ST_MEASURE && win_end) begin
                rem    <= prod_now;
                den    <= eff_len;
                quot   <= '0;
                step   <= STEP_W'(PCT_W - 1);
                over_q <= (prod_now > lim_now);
            end else if (state == ST_DIVIDE) begin
                if (fits)
                    rem <= rem - trial;
                quot <= quot_nxt;
                if (step != '0)
                    step <= step - STEP_W'(1);
                else
                    load_pct <= pct_sat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reconf_req <= 1'b0;
        else if (last_bit && over_q)
            reconf_req <= 1'b1;
        else if (req_clr)
            reconf_req <= 1'b0;
    end

    always_comb begin
        win_done = (state == ST_PUBLISH);
    end

    // R1: the publish strobe lasts a single cycle
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R4: the published load never exceeds full scale
    p_pct_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pct <= PCT_W'(PCT_FULL));

    // R5: the load value only moves together with the strobe
    p_pct_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> ($stable(load_pct) || win_done));

    // R6: the request only rises in a publish cycle
    p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconf_req) |-> win_done);

    // R7: the request is sticky without a clear
    p_req_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req && !req_clr) |=> reconf_req);

    // R7: a clear drops the request unless a new window sets it
    p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_clr |=> (!reconf_req || win_done));
endmodule

// File: rtl/link_load_meter.sv
module link_load_meter #(
    parameter int WIN_W   = 16,
    parameter int IFG_CYC = 24,
    parameter int MIN_WIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [WIN_W-1:0] win_len,
    input  logic [6:0]       thresh_pct,
    input  logic             req_clr,
    output logic [6:0]       load_pct,
    output logic             win_done,
    output logic             reconf_req
);
    localparam int SUM_W  = WIN_W + 5;
    localparam int PROD_W = SUM_W + 7;

    logic             win_end;
    logic [WIN_W-1:0] eff_len;
    logic [SUM_W-1:0] sum_now;

    llm_window_timer #(
        .WIN_W   (WIN_W),
        .MIN_WIN (MIN_WIN)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_len (win_len),
        .win_end (win_end),
        .eff_len (eff_len)
    );

    llm_activity_acc #(
        .WIN_W   (WIN_W),
        .SUM_W   (SUM_W),
        .IFG_CYC (IFG_CYC)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_dv   (rx_dv),
        .win_end (win_end),
        .sum_now (sum_now)
    );

    llm_ratio_fsm #(
        .WIN_W  (WIN_W),
        .SUM_W  (SUM_W),
        .PROD_W (PROD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end    (win_end),
        .sum_now    (sum_now),
        .eff_len    (eff_len),
        .thresh_pct (thresh_pct),
        .req_clr    (req_clr),
        .load_pct   (load_pct),
        .win_done   (win_done),
        .reconf_req (reconf_req)
    );

    // R1: a publish strobe never coincides with a window close
    p_done_apart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> !win_end);
endmodule

// File: tb/link_load_meter_test.sv
module link_load_meter_test;
    localparam int WIN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_dv = 1'b0;
    logic [WIN_W-1:0] win_len = 16'd100;
    logic [6:0]       thresh_pct = 7'd20;
    logic             req_clr = 1'b0;
    logic [6:0]       load_pct;
    logic             win_done;
    logic             reconf_req;

    int n_tests = 0;
    int n_fail  = 0;
    int n_pushed = 0;
    int n_popped = 0;
    bit finished = 0;

    typedef struct {
        int    pct;
        bit    req;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    bit m_prev = 0;
    bit m_req  = 0;

    always #10 clk = ~clk;

    link_load_meter #(.WIN_W(WIN_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_dv      (rx_dv),
        .win_len    (win_len),
        .thresh_pct (thresh_pct),
        .req_clr    (req_clr),
        .load_pct   (load_pct),
        .win_done   (win_done),
        .reconf_req (reconf_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: plays one window and pushes the expected result
    task automatic run_window(input int wl, input int lead, input int flen,
                              input int glen, input int thr, input int clr_at,
                              input string tag);
        int  eff;
        int  act;
        int  frm;
        longint s;
        longint pct;
        bit  over;
        eff = (wl < 16) ? 16 : wl;
        act = 0;
        frm = 0;
        for (int i = 0; i < eff; i++) begin
            bit dv;
            if (i < lead || flen == 0)
                dv = 0;
            else
                dv = (((i - lead) % (flen + glen)) < flen);
            if (i == clr_at + 1)
                check(reconf_req == 1'b0, {"R7 clear ", tag}, reconf_req, 0);
            rx_dv      = dv;
            win_len    = WIN_W'(wl);
            thresh_pct = 7'(thr);
            req_clr    = (i == clr_at);
            if (i == clr_at)
                m_req = 0;
            if (dv) act++;
            if (m_prev && !dv) frm++;
            m_prev = dv;
            @(negedge clk);
        end
        req_clr = 1'b0;
        s    = longint'(frm) * 24 + act;
        pct  = (100 * s) / eff;
        if (pct > 100) pct = 100;
        over = (100 * s) > (longint'(thr) * eff);
        if (over) m_req = 1;
        sb_q.push_back('{int'(pct), m_req, tag});
        n_pushed++;
    endtask

    // Monitor: pops an expectation on every publish strobe
    always @(negedge clk) begin
        if (rst_n && win_done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_popped++;
                check(load_pct == 7'(e.pct), {"R4 load ", e.tag}, load_pct, e.pct);
                check(reconf_req == e.req, {"R6 request ", e.tag}, reconf_req, e.req);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(load_pct == 7'd0, "R8 load in reset", load_pct, 0);
        check(win_done == 1'b0, "R8 strobe in reset", win_done, 0);
        check(reconf_req == 1'b0, "R8 request in reset", reconf_req, 0);
        rst_n = 1'b1;
        // R2 idle window
        run_window(200, 0, 0, 0, 20, -1, "idle");
        // R4 long frames at line rate
        run_window(248, 0, 100, 24, 20, -1, "long frames");
        // R4 short frames at line rate
        run_window(256, 0, 8, 24, 20, -1, "short frames");
        // R7 clear, light load 17 percent
        run_window(400, 0, 10, 190, 20, 20, "light");
        // R6 sum exactly at threshold: not over
        run_window(400, 0, 16, 184, 20, -1, "at threshold");
        // R6 one percent lower threshold: over
        run_window(400, 0, 16, 184, 19, -1, "over threshold");
        // R4 floor 22.67 -> 22, R6 6800 > 6600 sets again after clear
        run_window(300, 0, 10, 140, 22, 20, "floor");
        // R1 clamp to 16 cycles, R3 frame open at window end
        run_window(4, 12, 4, 0, 30, 10, "clamp");
        // R3 frame end lands in the next window
        run_window(200, 0, 0, 0, 30, -1, "carried end");
        // R6 zero threshold with zero load
        run_window(100, 0, 0, 0, 0, -1, "zero idle");
        // R2 single-cycle frame, zero threshold
        run_window(100, 50, 1, 49, 0, -1, "single cycle");
        rx_dv = 1'b0;
        repeat (12) @(negedge clk);
        check(n_popped == n_pushed, "R1 strobe count", n_popped, n_pushed);
        check(load_pct == 7'd25, "R5 load held", load_pct, 25);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule